// File: doc/BRIEF.md
# Triggered Fractional Clock-Enable Generator

This block sets the rate of one peripheral clock. The clock is expressed as a stream of single-cycle enable pulses. It takes a reference tick from one of several parent sources. An optional integer pre-divider and a main divider with a fractional part then scale that tick, and a phase accumulator turns the result into evenly spread enable pulses.

Software writes the new settings into shadow fields. Shadow writes have no effect on the output until a commit bit is written. There are two commit bits. The early commit moves the parent choice and the pre-divider into use. The late commit moves the main divider into use. Each commit bit reads as busy from the write until the new value is in use. A commit is honoured only while the clock gate is on. It waits out a short settling delay, then lands on a pulse boundary, so the output never produces a short period.

Top module: `trig_frac_clkgen`

## Requirements
- R1: After reset the gate is off, the active parent code is 3 (undefined), the divider fields are zero, both busy outputs are 0, and `clk_en_o` stays 0.
- R2: The main divider field (register 2, bits 11:0) holds the divisor minus one in units of 1/16. Bits 3:0 are the fraction, and the added one weighs 16 in those units. The scaled divisor D is field+16. With one source tick per cycle and pre-divisor P, every window of P*D cycles holds exactly 16 pulses.
- R3: The pre-divider field (register 1, bits 3:2) holds the pre-divisor minus one, so P = field+1, from 1 to 4.
- R4: The parent code (register 1, bits 1:0) values 0, 1 and 2 select `ref_tick[0]`, `ref_tick[1]` and `ref_tick[2]`. While code 3 is active, no pulses are produced.
- R5: Writing 1 to a commit bit (register 3) while the gate is on raises its busy output in the next cycle. Busy holds for at least 4 cycles. When no pulses are being produced, busy clears in the 5th cycle after the write.
- R6: Commit bit 1 moves only the parent code and the pre-divider into use. Commit bit 0 moves only the main divider into use.
- R7: A commit write while the gate (register 0, bit 0) is off is ignored. Busy stays 0 and the active settings keep their values.
- R8: While pulses are being produced, a commit takes effect only on a cycle that produces a pulse. Busy drops in the same cycle in which that pulse appears on `clk_en_o`.
- R9: While the gate is off, `clk_en_o` stays 0.
- R10: Writing a shadow field without a commit leaves the output rate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 gate, 1 parent/pre-divider, 2 main divider, 3 commit bits |
| wr_data | input | 12 | Write data |
| ref_tick | input | 3 | Reference tick of each parent source |
| clk_en_o | output | 1 | Clock-enable pulse stream |
| main_busy_o | output | 1 | Main divider commit in progress |
| pre_busy_o | output | 1 | Parent/pre-divider commit in progress |

## Verification
The bench measures rate through a window of P*D cycles, which holds exactly 16 pulses at any phase. An off-by-one in the divisor or pre-divisor encoding, or a fraction weighted wrongly, changes that count. It also checks the following cases:
- Commits split between the two bits. A design that committed everything on either bit would show the wrong rate.
- A commit while the gate is off. A design that accepted it would raise busy or change the rate.
- Shadow writes without a commit. A design that let them through would change the rate.
- The undefined parent code. A design that decoded it would emit pulses.
- A long-period commit. A design that applied it before the pulse boundary would drop busy without an accompanying pulse.

// File: rtl/trig_clkgen_pkg.sv
package trig_clkgen_pkg;

    localparam int INT_W       = 8;
    localparam int FRAC_W      = 4;
    localparam int DIV_W       = INT_W + FRAC_W;
    localparam int ACC_W       = DIV_W + 1;
    localparam int PRE_W       = 2;
    localparam int SEL_W       = 2;
    localparam int NUM_PARENTS = 3;
    localparam int SETTLE_CYC  = 3;
    localparam int ADDR_W      = 2;
    localparam int DATA_W      = DIV_W;
    localparam int NUM_TRIG    = 2;

    // commit bit positions in the commit register
    localparam int TRIG_MAIN = 0;
    localparam int TRIG_EARLY = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_GATE  = 2'd0,
        REG_EARLY = 2'd1,
        REG_DIV   = 2'd2,
        REG_TRIG  = 2'd3
    } reg_addr_e;

    // pre-divider in the upper bits, parent code in the lower bits
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SEL_W-1:0] sel;
    } early_cfg_t;

    localparam early_cfg_t EARLY_RESET = '{pre: '0, sel: '1};

    function automatic logic [ACC_W-1:0] scaled_divisor(input logic [DIV_W-1:0] field);
        return {1'b0, field} + ACC_W'(1 << FRAC_W);
    endfunction

    function automatic logic sel_is_valid(input logic [SEL_W-1:0] code);
        return int'(code) < NUM_PARENTS;
    endfunction

endpackage

// File: rtl/tcg_commit.sv
module tcg_commit #(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_wr,
    input  logic gate_on,
    input  logic boundary,
    output logic busy,
    output logic apply
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] settle_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            settle_q <= '0;
        end else if (trig_wr && gate_on) begin
            busy_q   <= 1'b1;
            settle_q <= CW'(SETTLE);
        end else if (busy_q) begin
            if (settle_q != '0)
                settle_q <= settle_q - 1'b1;
            else if (boundary)
                busy_q <= 1'b0;
        end
    end

    assign busy  = busy_q;
    assign apply = busy_q && (settle_q == '0) && boundary;

    a_r5_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        (trig_wr && gate_on) |=> busy);
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);
    a_r7_gate_off_ignored: assert property (@(posedge clk) disable iff (rst)
        (trig_wr && !gate_on && !busy) |=> !busy);
    a_r8_release_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(boundary));
endmodule

// File: rtl/tcg_predivider.sv
module tcg_predivider #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             src_tick,
    input  logic [PRE_W-1:0] pre_val,
    output logic             pre_tick
);
    logic [PRE_W-1:0] cnt_q;

    assign pre_tick = src_tick && (cnt_q == pre_val);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (pre_tick)
            cnt_q <= '0;
        else if (src_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= pre_val);
endmodule

// File: rtl/tcg_frac_accum.sv
module tcg_frac_accum
    import trig_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div_field,
    output logic             pulse
);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1 << FRAC_W);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] dsc;

    always_comb begin
        sum   = acc_q + ONE;
        dsc   = scaled_divisor(div_field);
        pulse = adv && (sum >= dsc);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (adv)
            acc_q <= pulse ? (sum - dsc) : sum;
    end

    a_r2_acc_below_divisor: assert property (@(posedge clk) disable iff (rst)
        acc_q < scaled_divisor(div_field));
endmodule

// File: rtl/trig_frac_clkgen.sv
module trig_frac_clkgen
    import trig_clkgen_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [NUM_PARENTS-1:0] ref_tick,
    output logic                   clk_en_o,
    output logic                   main_busy_o,
    output logic                   pre_busy_o
);
    logic             gate_q;
    early_cfg_t       shadow_early_q, act_early_q;
    logic [DIV_W-1:0] shadow_div_q, act_div_q;
    logic             clk_en_q;

    logic [NUM_TRIG-1:0] trig_wr, busy, apply;
    logic running, sel_tick, src_tick, pre_tick, pulse_now, boundary, restart;

    // register writes into shadow state
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q         <= 1'b0;
            shadow_early_q <= EARLY_RESET;
            shadow_div_q   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_GATE:  gate_q         <= wr_data[0];
                REG_EARLY: shadow_early_q <= early_cfg_t'(wr_data[PRE_W+SEL_W-1:0]);
                REG_DIV:   shadow_div_q   <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        trig_wr = '0;
        if (wr_en && reg_addr_e'(wr_addr) == REG_TRIG)
            trig_wr = wr_data[NUM_TRIG-1:0];
    end

    // parent selection
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_PARENTS; i++)
            if (act_early_q.sel == SEL_W'(i))
                sel_tick = ref_tick[i];
    end

    assign running  = gate_q && sel_is_valid(act_early_q.sel);
    assign src_tick = running && sel_tick;
    assign boundary = pulse_now || !running;
    assign restart  = |apply;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        tcg_commit #(.SETTLE(SETTLE_CYC)) u_commit (
            .clk      (clk),
            .rst      (rst),
            .trig_wr  (trig_wr[g]),
            .gate_on  (gate_q),
            .boundary (boundary),
            .busy     (busy[g]),
            .apply    (apply[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_early_q <= EARLY_RESET;
            act_div_q   <= '0;
        end else begin
            if (apply[TRIG_EARLY]) act_early_q <= shadow_early_q;
            if (apply[TRIG_MAIN])  act_div_q   <= shadow_div_q;
        end
    end

    tcg_predivider #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .src_tick (src_tick),
        .pre_val  (act_early_q.pre),
        .pre_tick (pre_tick)
    );

    tcg_frac_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (restart),
        .adv       (pre_tick),
        .div_field (act_div_q),
        .pulse     (pulse_now)
    );

    always_ff @(posedge clk) begin
        if (rst) clk_en_q <= 1'b0;
        else     clk_en_q <= pulse_now;
    end

    assign clk_en_o    = clk_en_q;
    assign main_busy_o = busy[TRIG_MAIN];
    assign pre_busy_o  = busy[TRIG_EARLY];

    a_r9_gate_off_silent: assert property (@(posedge clk) disable iff (rst)
        !gate_q |=> !clk_en_o);
    a_r4_undefined_parent_silent: assert property (@(posedge clk) disable iff (rst)
        !sel_is_valid(act_early_q.sel) |=> !clk_en_o);
    a_r8_divider_changes_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (act_div_q != $past(act_div_q)) |-> $past(boundary));
    a_r6_early_changes_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (act_early_q != $past(act_early_q)) |-> $past(boundary));
endmodule

// File: tb/trig_frac_clkgen_tb.sv
module trig_frac_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [11:0] wr_data;
    logic [2:0]  ref_tick;
    logic        clk_en_o, main_busy_o, pre_busy_o;

    logic [2:0]  tick_on   = 3'b000;
    logic        noise_on  = 1'b0;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;

    trig_frac_clkgen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_tick(ref_tick), .clk_en_o(clk_en_o),
        .main_busy_o(main_busy_o), .pre_busy_o(pre_busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk)
        ref_tick <= tick_on | (noise_on ? (3'($urandom) & ~tick_on) : 3'b000);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int window_len(input int pre, input int div);
        return (pre + 1) * (div + 16);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = 12'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((main_busy_o || pre_busy_o) && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic count_pulses(input int len, output int cnt);
        cnt = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (clk_en_o) cnt++;
        end
    endtask

    task automatic commit_all(input int sel, input int pre, input int div);
        tick_on = (sel < 3) ? 3'(1 << sel) : 3'b000;
        wr(1, (pre << 2) | sel);
        wr(2, div);
        wr(3, 3);
        wait_idle();
    endtask

    task automatic rate_check(input string req, input int pre, input int div);
        int cnt;
        count_pulses(window_len(pre, div), cnt);
        check(cnt == 16, req, cnt, 16);
    endtask

    initial begin
        int cnt;
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(main_busy_o == 0 && pre_busy_o == 0, "R1 busy after reset", {main_busy_o, pre_busy_o}, 0);
        tick_on = 3'b111;
        count_pulses(40, cnt);
        check(cnt == 0, "R1 silent after reset", cnt, 0);

        // R4 gate on, reset parent code 3 is undefined
        wr(0, 1);
        count_pulses(40, cnt);
        check(cnt == 0, "R4 undefined reset parent", cnt, 0);

        // R5 busy timing while not producing pulses
        wr(3, 1);
        check(main_busy_o == 1, "R5 busy +1", main_busy_o, 1);
        @(negedge clk); check(main_busy_o == 1, "R5 busy +2", main_busy_o, 1);
        @(negedge clk); check(main_busy_o == 1, "R5 busy +3", main_busy_o, 1);
        @(negedge clk); check(main_busy_o == 1, "R5 busy +4", main_busy_o, 1);
        @(negedge clk); check(main_busy_o == 0, "R5 busy +5 cleared", main_busy_o, 0);

        // R2 / R3 / R4 directed
        noise_on = 1'b1;
        commit_all(0, 0, 12'h000); rate_check("R2 divisor 1.0", 0, 12'h000);
        commit_all(1, 3, 12'h010); rate_check("R3 pre 4 div 2.0", 3, 12'h010);
        commit_all(2, 1, 12'h018); rate_check("R2 fraction 2.5", 1, 12'h018);
        commit_all(0, 2, 12'h007); rate_check("R2 fraction 1.4375", 2, 12'h007);

        // random configurations
        for (int k = 0; k < 8; k++) begin
            int s, p, d;
            s = int'($urandom % 3);
            p = int'($urandom % 4);
            d = int'($urandom % 256);
            commit_all(s, p, d);
            rate_check("R2 R3 R4 random", p, d);
        end

        // R4 undefined code committed
        commit_all(3, 0, 12'h000);
        tick_on = 3'b111;
        count_pulses(60, cnt);
        check(cnt == 0, "R4 undefined committed", cnt, 0);

        // R6 split commits
        commit_all(0, 0, 12'h020);
        wr(1, (1 << 2) | 1);
        wr(2, 12'h000);
        tick_on = 3'b010;
        wr(3, 2);
        wait_idle();
        rate_check("R6 early commit keeps old divider", 1, 12'h020);
        wr(3, 1);
        wait_idle();
        rate_check("R6 main commit applies divider", 1, 12'h000);

        // R10 shadow write without commit
        wr(2, 12'h0F0);
        repeat (5) @(negedge clk);
        rate_check("R10 shadow only", 1, 12'h000);

        // R7 commit with gate off
        wr(0, 0);
        wr(3, 3);
        check(main_busy_o == 0 && pre_busy_o == 0, "R7 busy stays low", {main_busy_o, pre_busy_o}, 0);
        @(negedge clk);
        check(main_busy_o == 0, "R7 busy stays low later", main_busy_o, 0);

        // R9 gate off silent
        count_pulses(50, cnt);
        check(cnt == 0, "R9 gate off", cnt, 0);
        wr(0, 1);
        repeat (2) @(negedge clk);
        rate_check("R7 rate unchanged", 1, 12'h000);

        // R8 long period: commit lands with a pulse
        commit_all(0, 3, 12'h0F0);
        wr(3, 1);
        repeat (10) @(negedge clk);
        check(main_busy_o == 1, "R8 waits for boundary", main_busy_o, 1);
        begin
            int n = 0;
            while (main_busy_o && n < 5000) begin
                @(negedge clk);
                n++;
            end
        end
        check(clk_en_o == 1, "R8 busy drops with pulse", clk_en_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule